// File: doc/BRIEF.md
# Four-Region Cartridge Bank Mapper

This block sits between a CPU with a 16-bit address bus and an 8-bit data bus and a cartridge ROM that is larger than the CPU can address. The CPU address space is cut into four 16 KiB windows. Each window has its own 8-bit bank register. The top two address bits pick the window, and the mapper builds a ROM address from that window's bank number followed by the 14-bit offset inside the window. Software changes the mapping by writing bank numbers to a few fixed addresses. Writes to these addresses never reach the ROM.

A separate 8-bit control register is loaded from one more fixed address, and its value is driven out so that neighbouring logic can use it. The SRAM port, for example, takes its enable from control bit 1. When control bit 2 is set, reads from a small group of addresses return the bank registers instead of ROM data. A flag tells the data-bus multiplexer when the mapper's own byte takes precedence over ROM data. The group of readback addresses ignores address bit 15, so it also appears in the upper half of the address space.

The ROM array, the SRAM storage and its address logic are outside this block.

Top module: `cart_bank_mapper`

## Requirements
- R1: Reset clears the control register and all four bank registers, so `rom_addr` equals `{8'h00, cpu_addr[13:0]}` for every address and `ctrl_out` is 0.
- R2: `rom_addr` is `{bank[cpu_addr[15:14]], cpu_addr[13:0]}`, where bank[0..3] are the four bank registers and bits [21:14] carry the bank number.
- R3: A write (`cpu_wr`=1 at a rising clock edge) to 0x6400 loads bank register 0, and a write to 0x6000 loads bank register 1.
- R4: A write to 0x7000 loads bank register 2, and a write to 0x7400 loads bank register 3.
- R5: A write to 0x7FF9 loads the control register, and its value appears on `ctrl_out` after that clock edge.
- R6: When control bit 2 is 1 and `cpu_rd` is 1 with `(cpu_addr & 16'h7FF9) == 16'h7FF0`, `rd_override` is 1 and `rd_data` is bank[cpu_addr[2:1]]. Reading 0x7FF0, 0x7FF2, 0x7FF4 and 0x7FF6 returns banks 0 to 3.
- R7: Address bit 15 is ignored by the readback match, so 0xFFF0 to 0xFFF6 (even addresses) return the same bytes as 0x7FF0 to 0x7FF6.
- R8: `rd_override` is 0 and `rd_data` is 0 when control bit 2 is 0, when `cpu_rd` is 0, or when the address fails the mask test (for example 0x7FF1 or 0x7FF8).
- R9: A write to any address other than the five register addresses, or a cycle with `cpu_wr`=0, leaves all bank registers and the control register unchanged.
- R10: A bank write does not change `rom_addr` during the cycle that carries the write. The new bank shows from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address for the current access |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| cpu_rd | input | 1 | Read strobe for the current access |
| rom_addr | output | 22 | Mapped ROM address: bank number and window offset |
| rd_data | output | 8 | Readback byte; zero unless `rd_override` is high |
| rd_override | output | 1 | High when `rd_data` replaces ROM data on this read |
| ctrl_out | output | 8 | Current control register value |

## Verification
A bank register that holds the wrong value, or that was loaded from the wrong address, shows up on `rom_addr[21:14]` on the first access to its window after the faulty write. It also shows on `rd_data` on the first readback of that register. The swapped addresses for windows 0 and 1 are the likeliest decode mistake. Such a mistake appears one cycle after the write, as soon as either window is read. A wrong control register shows at once on `ctrl_out`, and through a missing or spurious `rd_override` on the next read of a readback address.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    // CPU bus geometry
    localparam int CPU_AW      = 16;
    localparam int CPU_DW      = 8;
    localparam int REGIONS     = 4;
    localparam int REGION_SELW = $clog2(REGIONS);
    localparam int OFFSET_W    = CPU_AW - REGION_SELW;
    localparam int ROM_AW      = CPU_DW + OFFSET_W;

    // Register write addresses (decoded on the full address)
    localparam logic [CPU_AW-1:0] CTRL_WR_ADDR = 16'h7FF9;

    // Readback window: address matches RB_BASE under RB_MASK
    localparam logic [CPU_AW-1:0] RB_MASK = 16'h7FF9;
    localparam logic [CPU_AW-1:0] RB_BASE = 16'h7FF0;
    localparam int                RB_SEL_LSB = 1;

    // Control register bit that turns readback on
    localparam int CTRL_RB_BIT = 2;

    // Bank register write address for each region.
    // Regions 0 and 1 are deliberately swapped with respect to address order.
    function automatic logic [CPU_AW-1:0] bank_wr_addr(input int region);
        logic [CPU_AW-1:0] a;
        case (region)
            0:       a = 16'h6400;
            1:       a = 16'h6000;
            2:       a = 16'h7000;
            3:       a = 16'h7400;
            default: a = 16'h0000;
        endcase
        return a;
    endfunction

    // Load request produced by the decoder
    typedef struct packed {
        logic [REGIONS-1:0] bank_ld;
        logic               ctrl_ld;
    } load_req_t;

endpackage

// File: rtl/cbm_wr_decode.sv
module cbm_wr_decode
    import cbm_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int NR = REGIONS
) (
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    output load_req_t     load_req
);

    logic [NR-1:0] hit_bank;
    logic          hit_ctrl;

    // One exact-address comparator per bank register
    for (genvar r = 0; r < NR; r++) begin : g_bank_hit
        localparam logic [AW-1:0] KEY = AW'(bank_wr_addr(r));
        assign hit_bank[r] = (cpu_addr == KEY);
    end

    assign hit_ctrl = (cpu_addr == AW'(CTRL_WR_ADDR));

    always_comb begin
        load_req         = '0;
        load_req.ctrl_ld = cpu_wr & hit_ctrl;
        for (int r = 0; r < NR; r++) begin
            load_req.bank_ld[r] = cpu_wr & hit_bank[r];
        end
    end

endmodule

// File: rtl/cbm_regs.sv
module cbm_regs
    import cbm_pkg::*;
#(
    parameter int DW = CPU_DW,
    parameter int NR = REGIONS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  load_req_t        load_req,
    input  logic [DW-1:0]    wdata,
    output logic [NR*DW-1:0] bank_flat,
    output logic [DW-1:0]    ctrl
);

    typedef struct packed {
        logic [DW-1:0]          ctrl;
        logic [NR-1:0][DW-1:0]  bank;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_req.ctrl_ld) begin
            st_d.ctrl = wdata;
        end
        for (int r = 0; r < NR; r++) begin
            if (load_req.bank_ld[r]) begin
                st_d.bank[r] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar r = 0; r < NR; r++) begin : g_flat
        assign bank_flat[r*DW +: DW] = st_q.bank[r];
    end

    assign ctrl = st_q.ctrl;

endmodule

// File: rtl/cbm_rom_map.sv
module cbm_rom_map
    import cbm_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int DW = CPU_DW,
    parameter int NR = REGIONS
) (
    input  logic [AW-1:0]    cpu_addr,
    input  logic [NR*DW-1:0] bank_flat,
    output logic [ROM_AW-1:0] rom_addr
);

    localparam int SELW = $clog2(NR);
    localparam int OFFW = AW - SELW;

    logic [SELW-1:0] region;
    logic [DW-1:0]   bank_sel;

    assign region = cpu_addr[AW-1 -: SELW];

    always_comb begin
        bank_sel = '0;
        for (int r = 0; r < NR; r++) begin
            if (region == SELW'(r)) begin
                bank_sel = bank_flat[r*DW +: DW];
            end
        end
    end

    assign rom_addr = {bank_sel, cpu_addr[OFFW-1:0]};

endmodule

// File: rtl/cbm_readback.sv
module cbm_readback
    import cbm_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int DW = CPU_DW,
    parameter int NR = REGIONS
) (
    input  logic             cpu_rd,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             rb_en,
    input  logic [NR*DW-1:0] bank_flat,
    output logic [DW-1:0]    rd_data,
    output logic             rd_override
);

    localparam int SELW = $clog2(NR);

    logic            addr_hit;
    logic [SELW-1:0] sel;
    logic            unused_addr_top;

    // Bit 15 sits outside the mask, so the window is mirrored high and low
    assign addr_hit        = ((cpu_addr & AW'(RB_MASK)) == AW'(RB_BASE));
    assign sel             = cpu_addr[RB_SEL_LSB +: SELW];
    assign unused_addr_top = cpu_addr[AW-1];

    always_comb begin
        rd_override = cpu_rd & rb_en & addr_hit;
        rd_data     = '0;
        if (rd_override) begin
            for (int r = 0; r < NR; r++) begin
                if (sel == SELW'(r)) begin
                    rd_data = bank_flat[r*DW +: DW];
                end
            end
        end
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [CPU_DW-1:0] rd_data,
    output logic              rd_override,
    output logic [CPU_DW-1:0] ctrl_out
);

    load_req_t                 load_req;
    logic [REGIONS*CPU_DW-1:0] bank_flat;
    logic [CPU_DW-1:0]         ctrl_q;

    cbm_wr_decode #(.AW(CPU_AW), .NR(REGIONS)) u_dec (
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .load_req (load_req)
    );

    cbm_regs #(.DW(CPU_DW), .NR(REGIONS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load_req),
        .wdata     (cpu_wdata),
        .bank_flat (bank_flat),
        .ctrl      (ctrl_q)
    );

    cbm_rom_map #(.AW(CPU_AW), .DW(CPU_DW), .NR(REGIONS)) u_map (
        .cpu_addr  (cpu_addr),
        .bank_flat (bank_flat),
        .rom_addr  (rom_addr)
    );

    cbm_readback #(.AW(CPU_AW), .DW(CPU_DW), .NR(REGIONS)) u_rb (
        .cpu_rd      (cpu_rd),
        .cpu_addr    (cpu_addr),
        .rb_en       (ctrl_q[CTRL_RB_BIT]),
        .bank_flat   (bank_flat),
        .rd_data     (rd_data),
        .rd_override (rd_override)
    );

    assign ctrl_out = ctrl_q;

endmodule

// File: rtl/cbm_chk.sv
module cbm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input logic [21:0] rom_addr,
    input logic [7:0]  rd_data,
    input logic        rd_override,
    input logic [7:0]  ctrl_out
);

    AST_RESET_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_out == 8'h00)); // R1

    AST_REGION1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h6000) |=>
        (cpu_addr[15:14] != 2'd1 || rom_addr[21:14] == $past(cpu_wdata))); // R3

    AST_REGION0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h6400) |=>
        (cpu_addr[15:14] != 2'd0 || rom_addr[21:14] == $past(cpu_wdata))); // R3

    AST_REGION2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h7000) |=>
        (cpu_addr[15:14] != 2'd2 || rom_addr[21:14] == $past(cpu_wdata))); // R4

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h7FF9) |=> (ctrl_out == $past(cpu_wdata))); // R5

    AST_OVERRIDE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_override |-> (cpu_rd && ctrl_out[2])); // R6

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_override |-> (rd_data == 8'h00)); // R8

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == 16'h7FF9) |=> $stable(ctrl_out)); // R9

endmodule

bind cart_bank_mapper cbm_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .rom_addr    (rom_addr),
    .rd_data     (rd_data),
    .rd_override (rd_override),
    .ctrl_out    (ctrl_out)
);

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        wr;
    logic        rd;
    wire  [21:0] rom_addr;
    wire  [7:0]  rd_data;
    wire         rd_override;
    wire  [7:0]  ctrl_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] bank_m [4];
    logic [7:0] ctrl_m;

    always #10 clk = ~clk;

    cart_bank_mapper u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (addr),
        .cpu_wdata   (wdata),
        .cpu_wr      (wr),
        .cpu_rd      (rd),
        .rom_addr    (rom_addr),
        .rd_data     (rd_data),
        .rd_override (rd_override),
        .ctrl_out    (ctrl_out)
    );

    function automatic logic [21:0] exp_rom(input logic [15:0] a);
        return {bank_m[a[15:14]], a[13:0]};
    endfunction

    function automatic logic exp_ovr(input logic [15:0] a, input logic r);
        return r && ctrl_m[2] && ((a & 16'h7FF9) == 16'h7FF0);
    endfunction

    function automatic logic [7:0] exp_data(input logic [15:0] a, input logic r);
        return exp_ovr(a, r) ? bank_m[a[2:1]] : 8'h00;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        case (a)
            16'h6400: bank_m[0] = d;
            16'h6000: bank_m[1] = d;
            16'h7000: bank_m[2] = d;
            16'h7400: bank_m[3] = d;
            16'h7FF9: ctrl_m    = d;
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
        @(posedge clk);
        #1;
        model_write(a, d);
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic r);
        @(negedge clk);
        addr = a; rd = r; wr = 1'b0;
        #2;
        check(req, "rom_addr", 32'(rom_addr), 32'(exp_rom(a)));
        check(req, "rd_override", 32'(rd_override), 32'(exp_ovr(a, r)));
        check(req, "rd_data", 32'(rd_data), 32'(exp_data(a, r)));
    endtask

    task automatic check_ctrl(input string req);
        #1;
        check(req, "ctrl_out", 32'(ctrl_out), 32'(ctrl_m));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pick [6];
        void'($urandom(32'd24680));
        pick[0] = 16'h6000; pick[1] = 16'h6400; pick[2] = 16'h7000;
        pick[3] = 16'h7400; pick[4] = 16'h7FF9; pick[5] = 16'h0000;
        for (int i = 0; i < 4; i++) bank_m[i] = 8'h00;
        ctrl_m = 8'h00;
        rst_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
        repeat (3) @(posedge clk);

        // R1: reset state
        check_ctrl("R1");
        probe("R1", 16'h0123, 1'b0);
        probe("R1", 16'h4567, 1'b1);
        probe("R1", 16'h89AB, 1'b0);
        probe("R1", 16'hCDEF, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: swapped low regions
        do_write(16'h6400, 8'hA5);
        probe("R3", 16'h0010, 1'b0);
        probe("R3", 16'h4010, 1'b0);
        do_write(16'h6000, 8'h5A);
        probe("R3", 16'h4000, 1'b1);
        probe("R3", 16'h3FFF, 1'b0);

        // R4: upper regions
        do_write(16'h7000, 8'h33);
        do_write(16'h7400, 8'hCC);
        probe("R4", 16'h8000, 1'b0);
        probe("R4", 16'hFFFF, 1'b0);

        // R8: readback off by default
        probe("R8", 16'h7FF0, 1'b1);

        // R5: control register
        do_write(16'h7FF9, 8'h04);
        check_ctrl("R5");

        // R6: readback of each bank
        probe("R6", 16'h7FF0, 1'b1);
        probe("R6", 16'h7FF2, 1'b1);
        probe("R6", 16'h7FF4, 1'b1);
        probe("R6", 16'h7FF6, 1'b1);

        // R7: mirror in the upper half
        probe("R7", 16'hFFF0, 1'b1);
        probe("R7", 16'hFFF6, 1'b1);

        // R8: mask misses and no read strobe
        probe("R8", 16'h7FF1, 1'b1);
        probe("R8", 16'h7FF8, 1'b1);
        probe("R8", 16'h7FF2, 1'b0);
        do_write(16'h7FF9, 8'h02);
        check_ctrl("R5");
        probe("R8", 16'h7FF2, 1'b1);

        // R9: near-miss addresses and strobe low
        do_write(16'h6001, 8'h77);
        do_write(16'h7FFA, 8'h77);
        do_write(16'h3FFD, 8'h77);
        check_ctrl("R9");
        @(negedge clk);
        addr = 16'h6400; wdata = 8'h11; wr = 1'b0; rd = 1'b0;
        @(negedge clk);
        addr = 16'h7FF9; wdata = 8'h11;
        @(posedge clk);
        check_ctrl("R9");
        probe("R9", 16'h0000, 1'b0);
        probe("R9", 16'h4000, 1'b0);
        probe("R9", 16'h8000, 1'b0);
        probe("R9", 16'hC000, 1'b0);

        // R10: new bank shows only after the capturing edge
        @(negedge clk);
        addr = 16'h6000; wdata = 8'h9C; wr = 1'b1; rd = 1'b0;
        #2;
        check("R10", "rom_addr before edge", 32'(rom_addr), 32'(exp_rom(16'h6000)));
        @(posedge clk);
        #1;
        model_write(16'h6000, 8'h9C);
        @(negedge clk);
        wr = 1'b0;
        #2;
        check("R10", "rom_addr after edge", 32'(rom_addr), 32'(exp_rom(16'h6000)));

        // R2: random mix of writes and accesses
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            if (($urandom % 3) == 0) begin
                a = pick[$urandom % 6];
                if (a == 16'h0000) a = 16'($urandom);
                do_write(a, 8'($urandom));
                check_ctrl("R2");
            end else begin
                a = 16'($urandom);
                if (($urandom % 3) == 0) a = {a[15], 12'hFF8, 3'b000} | 16'(($urandom % 4) * 2);
                probe("R2", a, 1'($urandom));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule